// File: doc/BRIEF.md
# LFSR Modulo-N Clock Divider

This block divides its input clock by a fixed integer N and marks each completed period with a pulse one clock wide on `tick_o`. It counts with a small shift register that has XNOR feedback instead of a binary adder. The register starts in a chosen start state and steps along the shift-register sequence. When it reaches a chosen end state, the next clock loads the start state again and raises the pulse. The divide ratio is therefore the number of sequence steps from start to end, plus one. With XNOR feedback the forbidden state is all-ones, so both the start and the end state must avoid it. Any ratio up to 2^WIDTH-1 can be reached with one equality compare and no carry chain.

All settings are parameters: register width, tap mask, start state and end state. The package provides functions that step the sequence and count the period, so that a checker can work out N for any setting. The reset is asynchronous and active high.

Top module: `lfsr_clkdiv`

## Requirements
- R1: While `rst` is high, `tick_o` is low (this takes effect asynchronously) and the register holds the start state, so counting always restarts from the start state after `rst` falls.
- R2: On each step, bit 0 takes the top bit. Every higher bit i takes bit i-1 XNOR the top bit if TAPS[i] is 1, and takes bit i-1 unchanged otherwise. The default mask is 4'b0010, so only bit 1 is tapped.
- R3: If the register equals END_STATE, the next rising edge loads START_STATE and drives `tick_o` high for exactly that one cycle.
- R4: On every other rising edge, the register advances one step and `tick_o` is low.
- R5: With the defaults (WIDTH 4, START_STATE 4'b0000, END_STATE 4'b0101), N is 13. The first pulse appears after the 13th rising edge following the fall of `rst`, and later pulses follow every 13 edges.
- R6: The register never holds the all-ones state.
- R7: The distance between two consecutive pulses is always N, which equals the number of steps from start to end plus one. This holds over 100 or more periods.
- R8: If END_STATE equals START_STATE, N is 1 and `tick_o` stays high on every cycle after the first edge following reset.
- R9: With START_STATE 4'b0000 and END_STATE 4'b0001 at the default mask, N is 15, the full length of the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Asynchronous reset, active high |
| tick_o | output | 1 | Pulse one cycle wide, once every N clocks |

## Verification
The only output is the pulse, so any fault inside shows up as a change in pulse timing. A wrong feedback bit, a wrong end compare or a missed reload moves a pulse or removes it. This is visible in the first period after reset, at most N edges in. A register that lands in the all-ones state never matches the end state again, so the pulses stop. The bench sees this as an interval that never closes. The bench measures every interval against a period it works out with its own model of the sequence. The bound checker compares internal state with the reload and advance rules on every edge.

// File: rtl/lfsr_clkdiv_pkg.sv
package lfsr_clkdiv_pkg;
  localparam int MAX_W = 32;
  typedef logic [MAX_W-1:0] wide_t;

  // One XNOR-feedback step of a w-bit register.
  function automatic wide_t lfsr_step(input wide_t q, input wide_t taps, input int w);
    wide_t r;
    logic  top;
    r   = '0;
    top = q[w-1];
    r[0] = top;
    for (int i = 1; i < MAX_W; i++) begin
      if (i < w) r[i] = taps[i] ? ~(q[i-1] ^ top) : q[i-1];
    end
    return r;
  endfunction

  // Number of clocks between pulses: steps from start to end, plus one.
  function automatic int lfsr_period(input wide_t s, input wide_t e,
                                     input wide_t taps, input int w);
    wide_t cur;
    int    n;
    cur = s;
    n   = 1;
    for (int k = 0; k < (1 << w); k++) begin
      if (cur == e) break;
      cur = lfsr_step(cur, taps, w);
      n++;
    end
    return n;
  endfunction
endpackage

// File: rtl/lfsr_clkdiv_next.sv
module lfsr_clkdiv_next #(
  parameter int               WIDTH = 4,
  parameter logic [WIDTH-1:0] TAPS  = 4'b0010
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] nxt_o
);
  localparam int TOP = WIDTH - 1;

  logic fb;
  assign fb       = cur_i[TOP];
  assign nxt_o[0] = fb;

  for (genvar b = 1; b < WIDTH; b++) begin : g_bit
    if (TAPS[b]) begin : g_tap
      assign nxt_o[b] = cur_i[b-1] ~^ fb;
    end else begin : g_pass
      assign nxt_o[b] = cur_i[b-1];
    end
  end
endmodule

// File: rtl/lfsr_clkdiv_match.sv
module lfsr_clkdiv_match #(
  parameter int               WIDTH     = 4,
  parameter logic [WIDTH-1:0] END_STATE = 4'b0101
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic             hit_o
);
  assign hit_o = (cur_i == END_STATE);
endmodule

// File: rtl/lfsr_clkdiv.sv
module lfsr_clkdiv #(
  parameter int               WIDTH       = 4,
  parameter logic [WIDTH-1:0] TAPS        = 4'b0010,
  parameter logic [WIDTH-1:0] START_STATE = 4'b0000,
  parameter logic [WIDTH-1:0] END_STATE   = 4'b0101
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_step;
  logic             at_end;

  lfsr_clkdiv_next #(.WIDTH(WIDTH), .TAPS(TAPS)) u_next (
    .cur_i (state_q),
    .nxt_o (state_step)
  );

  lfsr_clkdiv_match #(.WIDTH(WIDTH), .END_STATE(END_STATE)) u_match (
    .cur_i (state_q),
    .hit_o (at_end)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= START_STATE;
      tick_o  <= 1'b0;
    end else if (at_end) begin
      state_q <= START_STATE;
      tick_o  <= 1'b1;
    end else begin
      state_q <= state_step;
      tick_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/lfsr_clkdiv_chk.sv
module lfsr_clkdiv_chk #(
  parameter int               WIDTH       = 4,
  parameter logic [WIDTH-1:0] TAPS        = 4'b0010,
  parameter logic [WIDTH-1:0] START_STATE = 4'b0000,
  parameter logic [WIDTH-1:0] END_STATE   = 4'b0101
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic [WIDTH-1:0] state,
  input logic             at_end
);
  import lfsr_clkdiv_pkg::*;

  localparam int PERIOD = lfsr_period(wide_t'(START_STATE), wide_t'(END_STATE),
                                      wide_t'(TAPS), WIDTH);
  localparam logic [WIDTH-1:0] LOCK = '1;

  int gap;
  always_ff @(posedge clk or posedge rst) begin
    if (rst)       gap <= 0;
    else if (tick) gap <= 1;
    else           gap <= gap + 1;
  end

  AST_RELOAD:    assert property (@(posedge clk) disable iff (rst) at_end |=> (state == START_STATE) && tick); // R3
  AST_ADVANCE:   assert property (@(posedge clk) disable iff (rst) !at_end |=> !tick && (state != $past(state))); // R4
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst) state != LOCK); // R6
  AST_PERIOD:    assert property (@(posedge clk) disable iff (rst) tick |-> gap == PERIOD); // R7
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst) !tick |-> gap < PERIOD); // R7
endmodule

bind lfsr_clkdiv lfsr_clkdiv_chk #(
  .WIDTH(WIDTH), .TAPS(TAPS), .START_STATE(START_STATE), .END_STATE(END_STATE)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick_o), .state(state_q), .at_end(at_end)
);

// File: tb/tb_lfsr_clkdiv.sv
`timescale 1ns/1ps
module tb_lfsr_clkdiv;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_main, tick_one, tick_full;
  int   errors = 0;
  int   checks = 0;
  bit   done   = 1'b0;

  always #5 clk = ~clk;

  lfsr_clkdiv dut (.clk(clk), .rst(rst), .tick_o(tick_main));
  lfsr_clkdiv #(.START_STATE(4'b0110), .END_STATE(4'b0110)) dut_one (
    .clk(clk), .rst(rst), .tick_o(tick_one));
  lfsr_clkdiv #(.START_STATE(4'b0000), .END_STATE(4'b0001)) dut_full (
    .clk(clk), .rst(rst), .tick_o(tick_full));

  // Bench model of R2: shift left, top bit wraps to bit 0, tapped bits flip when top is 0.
  function automatic logic [3:0] model_step(input logic [3:0] q, input logic [3:0] m);
    logic t;
    t = q[3];
    return {q[2:0], t} ^ ({4{~t}} & m & 4'b1110);
  endfunction

  function automatic int model_n(input logic [3:0] s, input logic [3:0] e);
    logic [3:0] c;
    int k;
    c = s;
    k = 1;
    while (c != e && k < 20) begin
      c = model_step(c, 4'b0010);
      k++;
    end
    return k;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Edge number after reset release, expected tick (R5 defaults, N = 13).
  localparam int NV = 9;
  localparam int VEC_EDGE [NV] = '{1, 2, 12, 13, 14, 25, 26, 27, 39};
  localparam bit VEC_TICK [NV] = '{0, 0, 0, 1, 0, 0, 1, 0, 1};

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R1 tick low during reset", tick_main, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Measure count intervals on a chosen output.
  task automatic measure(input int which, input int periods, input int exp, input string req);
    int gap;
    int seen;
    logic t;
    gap = 0;
    seen = -1;
    while (seen < periods) begin
      @(negedge clk);
      gap++;
      t = (which == 0) ? tick_main : tick_full;
      if (t) begin
        if (seen >= 0) check(req, gap, exp);
        seen++;
        gap = 0;
      end
    end
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cur;
    #12;
    check("R1 reset state tick", tick_main, 0);
    @(negedge clk);
    rst = 1'b0;

    // R5 table walk
    cur = 0;
    for (int v = 0; v < NV; v++) begin
      repeat (VEC_EDGE[v] - cur) @(posedge clk);
      cur = VEC_EDGE[v];
      @(negedge clk);
      check($sformatf("R5 R3 R4 edge %0d", cur), tick_main, VEC_TICK[v]);
    end

    // R2 via bench model, R5 default ratio
    check("R2 R5 model ratio default", model_n(4'b0000, 4'b0101), 13);

    // R7: 110 periods on default instance
    measure(0, 110, model_n(4'b0000, 4'b0101), "R7 interval");

    // R9: full-length ratio
    check("R9 model ratio full", model_n(4'b0000, 4'b0001), 15);
    measure(1, 10, 15, "R9 interval");

    // R8: N = 1, tick high every cycle
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R8 tick every cycle", tick_one, 1);
    end

    // R1: asynchronous reset mid-cycle, then restart from start state
    @(posedge clk);
    #2;
    rst = 1'b1;
    #1;
    check("R1 async clear", tick_one, 0);
    do_reset();
    cur = 0;
    for (int v = 0; v < 5; v++) begin
      repeat (VEC_EDGE[v] - cur) @(posedge clk);
      cur = VEC_EDGE[v];
      @(negedge clk);
      check($sformatf("R1 restart edge %0d", cur), tick_main, VEC_TICK[v]);
    end

    // R6: lockup would stop pulses; confirm pulses continue
    measure(0, 5, 13, "R6 pulses continue");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule